// File: doc/BRIEF.md
# Serial Audio Port Control Registers

This block holds the control state for a synchronous serial audio port. Three control words and one watermark word sit behind a plain write/read bus. One word covers the port as a whole, one covers the transmit side and one covers the receive side. Every control bit that the serial datapath needs is also driven out as a dedicated output.

A two-bit mode field selects normal operation, I2S master or I2S slave. In either I2S mode, five control bits are held at the values that I2S framing requires. Software writes to those bits are then discarded, but the values software stored before the mode change are kept. They become visible again when the port goes back to normal mode.

The block also compares the fill level of the external transmit FIFO with a programmable watermark. From that it produces a transmit-empty flag and a gated interrupt. Reads are combinational on the address. Writes take effect at the rising clock edge on which `bus_wr` is high.

Top module: `sap_ctrl_regs`

## Requirements
- R1: The mode field is bits [2:1] of word 0. Value 01 selects I2S master (`i2s_master`=1), 10 selects I2S slave (`i2s_slave`=1), and 00 and 11 both select normal mode (both outputs 0).
- R2: In normal mode no bit is overridden. The sync bit (word 0 bit 3), the network bit (word 0 bit 4), the transmit LSB-first bit (word 1 bit 2), the transmit falling-edge bit (word 1 bit 3) and the receive LSB-first bit (word 2 bit 0) read back and drive their outputs exactly as written.
- R3: In either I2S mode, the sync and network bits read 1 and `sync_mode` and `net_mode` are 1.
- R4: In either I2S mode, the transmit and receive LSB-first bits read 0, meaning MSB first.
- R5: In either I2S mode, the transmit falling-edge bit reads 1 and `tx_clk_fall` is 1.
- R6: A write arriving while an I2S mode is in effect (the mode before that write) leaves the stored values of the five forced bits unchanged. The other bits of the same write, including the mode field, are updated.
- R7: After a return to normal mode, the forced bits read the values software last stored in them while in normal mode.
- R8: The transmit-empty flag (word 0 bit 0, output `tx_empty`) is 1 when the FIFO enable (word 1 bit 0) is 1 and `tx_level` is less than or equal to the watermark (word 3 bits [3:0]).
- R9: With the FIFO enable at 0, the transmit-empty flag is 0 for any fill level.
- R10: `tx_empty_irq` is 1 only when the flag, the interrupt enable (word 1 bit 1) and the FIFO enable are all 1.
- R11: After reset, words 0 to 2 read 0 (normal mode) and word 3 reads 8.
- R12: Word 0 bit 0 ignores writes. Word 3 bits above the watermark field read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Word address (0 port, 1 transmit, 2 receive, 3 watermark) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| tx_level | input | 5 | External transmit FIFO fill level |
| i2s_master | output | 1 | I2S master mode selected |
| i2s_slave | output | 1 | I2S slave mode selected |
| sync_mode | output | 1 | Effective synchronous-mode control |
| net_mode | output | 1 | Effective network-mode control |
| tx_lsb_first | output | 1 | Effective transmit shift direction |
| rx_lsb_first | output | 1 | Effective receive shift direction |
| tx_clk_fall | output | 1 | Effective transmit clock polarity |
| tx_fifo_en | output | 1 | Transmit FIFO enable |
| tx_empty | output | 1 | Transmit-empty flag |
| tx_empty_irq | output | 1 | Gated transmit-empty interrupt |

## Verification
The bench stores the opposite of the I2S values in the forced bits, enters master mode and then writes the bits again. A design that dropped the shadow copy, or let writes through, would read wrong values after the return to normal mode. It also writes a word that selects normal mode and sets the sync and network bits while slave mode is in effect. A design that judged the write against the new mode instead of the old one would accept those bits. The watermark compare is tested at equality and one step past it, at watermark 0 and at watermark 15 with a full level of 16, so an off-by-one or a truncated level would show. The interrupt is tested with each of its three enables missing in turn.

// File: rtl/sap_ctrl_pkg.sv
package sap_ctrl_pkg;

  localparam int unsigned NUM_CTL  = 3;
  localparam int unsigned W_PORT   = 0;
  localparam int unsigned W_TX     = 1;
  localparam int unsigned W_RX     = 2;
  localparam int unsigned ADDR_WM  = 3;

  // bit positions
  localparam int unsigned B_TXE     = 0;
  localparam int unsigned B_MODE_LO = 1;
  localparam int unsigned B_SYNC    = 3;
  localparam int unsigned B_NET     = 4;
  localparam int unsigned B_TX_FEN  = 0;
  localparam int unsigned B_TX_IEN  = 1;
  localparam int unsigned B_TX_LSB  = 2;
  localparam int unsigned B_TX_FALL = 3;
  localparam int unsigned B_RX_LSB  = 0;

  typedef enum logic [1:0] {
    MODE_NORM_A  = 2'b00,
    MODE_I2S_MST = 2'b01,
    MODE_I2S_SLV = 2'b10,
    MODE_NORM_B  = 2'b11
  } sap_mode_e;

  function automatic logic f_is_i2s(input logic [1:0] m);
    return (m == MODE_I2S_MST) || (m == MODE_I2S_SLV);
  endfunction

  // bits held by I2S framing, per control word (low byte)
  function automatic logic [7:0] f_force_mask(input int unsigned idx);
    case (idx)
      W_PORT:  return 8'h18;
      W_TX:    return 8'h0C;
      W_RX:    return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  // values of those bits while an I2S mode is active
  function automatic logic [7:0] f_force_val(input int unsigned idx);
    case (idx)
      W_PORT:  return 8'h18;
      W_TX:    return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  // bits that software can never write
  function automatic logic [7:0] f_ro_mask(input int unsigned idx);
    return (idx == W_PORT) ? 8'h01 : 8'h00;
  endfunction

  // fill level at or below watermark, only meaningful with FIFO on
  function automatic logic f_txe_hit(input int unsigned level,
                                     input int unsigned wm,
                                     input logic fifo_on);
    return fifo_on && (level <= wm);
  endfunction

endpackage

// File: rtl/sap_reg_word.sv
module sap_reg_word #(
  parameter int unsigned W   = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] keep,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST;
    else if (wr_en) q <= (wdata & ~keep) | (q & keep);
  end

endmodule

// File: rtl/sap_mode_force.sv
module sap_mode_force
  import sap_ctrl_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                       i2s_on,
  input  logic [NUM_CTL-1:0][W-1:0]  raw_q,
  output logic [NUM_CTL-1:0][W-1:0]  eff_q
);

  localparam int unsigned PAD = W - 8;

  for (genvar g = 0; g < NUM_CTL; g++) begin : g_word
    logic [W-1:0] fmask;
    logic [W-1:0] fval;
    assign fmask = {{PAD{1'b0}}, f_force_mask(g)};
    assign fval  = {{PAD{1'b0}}, f_force_val(g)};
    assign eff_q[g] = i2s_on ? ((raw_q[g] & ~fmask) | fval) : raw_q[g];
  end

endmodule

// File: rtl/sap_txe_status.sv
module sap_txe_status
  import sap_ctrl_pkg::*;
#(
  parameter int unsigned LVL_W = 4
) (
  input  logic [LVL_W:0]   level,
  input  logic [LVL_W-1:0] wm,
  input  logic             fifo_en,
  input  logic             irq_en,
  output logic             flag,
  output logic             irq
);

  assign flag = f_txe_hit(int'(level), int'(wm), fifo_en);
  assign irq  = flag && irq_en && fifo_en;

endmodule

// File: rtl/sap_ctrl_regs.sv
module sap_ctrl_regs
  import sap_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LVL_W  = 4,
  parameter int unsigned WM_RST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [LVL_W:0]    tx_level,
  output logic              i2s_master,
  output logic              i2s_slave,
  output logic              sync_mode,
  output logic              net_mode,
  output logic              tx_lsb_first,
  output logic              rx_lsb_first,
  output logic              tx_clk_fall,
  output logic              tx_fifo_en,
  output logic              tx_empty,
  output logic              tx_empty_irq
);

  localparam int unsigned PAD  = DATA_W - 8;
  localparam int unsigned WPAD = DATA_W - LVL_W;

  logic [NUM_CTL-1:0][DATA_W-1:0] raw_q;
  logic [NUM_CTL-1:0][DATA_W-1:0] eff_q;
  logic [LVL_W-1:0]               wm_q;
  logic [1:0]                     mode;
  logic                           i2s_on;
  logic                           ctl_wr;
  logic                           forced_wr_blocked;
  logic                           txe_flag;
  logic                           txe_irq;

  assign mode   = raw_q[W_PORT][B_MODE_LO +: 2];
  assign i2s_on = f_is_i2s(mode);
  assign ctl_wr = bus_wr && (int'(bus_addr) < NUM_CTL);
  assign forced_wr_blocked = ctl_wr && i2s_on;

  for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
    logic [DATA_W-1:0] keep;
    logic              hit;
    assign keep = {{PAD{1'b0}}, f_ro_mask(g) | (i2s_on ? f_force_mask(g) : 8'h00)};
    assign hit  = bus_wr && (int'(bus_addr) == g);
    sap_reg_word #(.W(DATA_W), .RST('0)) u_word (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (hit),
      .wdata (bus_wdata),
      .keep  (keep),
      .q     (raw_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wm_q <= LVL_W'(WM_RST);
    else if (bus_wr && (int'(bus_addr) == ADDR_WM))
      wm_q <= bus_wdata[LVL_W-1:0];
  end

  sap_mode_force #(.W(DATA_W)) u_force (
    .i2s_on (i2s_on),
    .raw_q  (raw_q),
    .eff_q  (eff_q)
  );

  sap_txe_status #(.LVL_W(LVL_W)) u_txe (
    .level   (tx_level),
    .wm      (wm_q),
    .fifo_en (eff_q[W_TX][B_TX_FEN]),
    .irq_en  (eff_q[W_TX][B_TX_IEN]),
    .flag    (txe_flag),
    .irq     (txe_irq)
  );

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = eff_q[W_PORT] | {{(DATA_W-1){1'b0}}, txe_flag};
      2'd1:    bus_rdata = eff_q[W_TX];
      2'd2:    bus_rdata = eff_q[W_RX];
      default: bus_rdata = {{WPAD{1'b0}}, wm_q};
    endcase
  end

  assign i2s_master   = (mode == MODE_I2S_MST);
  assign i2s_slave    = (mode == MODE_I2S_SLV);
  assign sync_mode    = eff_q[W_PORT][B_SYNC];
  assign net_mode     = eff_q[W_PORT][B_NET];
  assign tx_lsb_first = eff_q[W_TX][B_TX_LSB];
  assign tx_clk_fall  = eff_q[W_TX][B_TX_FALL];
  assign rx_lsb_first = eff_q[W_RX][B_RX_LSB];
  assign tx_fifo_en   = eff_q[W_TX][B_TX_FEN];
  assign tx_empty     = txe_flag;
  assign tx_empty_irq = txe_irq;

  logic unused_pad;
  assign unused_pad = ^{eff_q[W_PORT][DATA_W-1:5], eff_q[W_RX][DATA_W-1:1],
                        eff_q[W_TX][DATA_W-1:4], PAD[0]};

endmodule

// File: rtl/sap_ctrl_regs_chk.sv
module sap_ctrl_regs_chk
  import sap_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_wr,
  input logic [1:0]                     bus_addr,
  input logic [DATA_W-1:0]              bus_wdata,
  input logic [NUM_CTL-1:0][DATA_W-1:0] raw_q,
  input logic                           i2s_on,
  input logic                           forced_wr_blocked,
  input logic                           i2s_master,
  input logic                           i2s_slave,
  input logic                           sync_mode,
  input logic                           net_mode,
  input logic                           tx_lsb_first,
  input logic                           rx_lsb_first,
  input logic                           tx_clk_fall,
  input logic                           tx_fifo_en,
  input logic                           tx_empty,
  input logic                           tx_empty_irq
);

  p_mode_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({i2s_master, i2s_slave}));

  p_normal_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && !i2s_on && !f_is_i2s(bus_wdata[2:1]))
    |=> (sync_mode == $past(bus_wdata[B_SYNC])) && (net_mode == $past(bus_wdata[B_NET])));

  p_i2s_sync_net_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (i2s_master || i2s_slave) |-> (sync_mode && net_mode));

  p_i2s_msb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (i2s_master || i2s_slave) |-> (!tx_lsb_first && !rx_lsb_first));

  p_i2s_clk_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (i2s_master || i2s_slave) |-> tx_clk_fall);

  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    forced_wr_blocked |=> $stable(raw_q[W_TX][B_TX_LSB]) && $stable(raw_q[W_TX][B_TX_FALL])
                          && $stable(raw_q[W_RX][B_RX_LSB]) && $stable(raw_q[W_PORT][B_SYNC])
                          && $stable(raw_q[W_PORT][B_NET]));

  p_flag_needs_fifo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_fifo_en |-> !tx_empty);

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_irq |-> (tx_empty && tx_fifo_en && raw_q[W_TX][B_TX_IEN]));

endmodule

bind sap_ctrl_regs sap_ctrl_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .bus_wr            (bus_wr),
  .bus_addr          (bus_addr),
  .bus_wdata         (bus_wdata),
  .raw_q             (raw_q),
  .i2s_on            (i2s_on),
  .forced_wr_blocked (forced_wr_blocked),
  .i2s_master        (i2s_master),
  .i2s_slave         (i2s_slave),
  .sync_mode         (sync_mode),
  .net_mode          (net_mode),
  .tx_lsb_first      (tx_lsb_first),
  .rx_lsb_first      (rx_lsb_first),
  .tx_clk_fall       (tx_clk_fall),
  .tx_fifo_en        (tx_fifo_en),
  .tx_empty          (tx_empty),
  .tx_empty_irq      (tx_empty_irq)
);

// File: tb/sap_ctrl_regs_test.sv
module sap_ctrl_regs_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [4:0]  tx_level = 5'd15;
  logic i2s_master, i2s_slave, sync_mode, net_mode, tx_lsb_first, rx_lsb_first;
  logic tx_clk_fall, tx_fifo_en, tx_empty, tx_empty_irq;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sap_ctrl_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_level(tx_level),
    .i2s_master(i2s_master), .i2s_slave(i2s_slave), .sync_mode(sync_mode),
    .net_mode(net_mode), .tx_lsb_first(tx_lsb_first), .rx_lsb_first(rx_lsb_first),
    .tx_clk_fall(tx_clk_fall), .tx_fifo_en(tx_fifo_en), .tx_empty(tx_empty),
    .tx_empty_irq(tx_empty_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string req);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    rd(2'd0, 16'h0000, "R11 word0");
    rd(2'd1, 16'h0000, "R11 word1");
    rd(2'd2, 16'h0000, "R11 word2");
    rd(2'd3, 16'h0008, "R11 word3");
    chk("R11 irq", tx_empty_irq, 0);
  endtask

  task automatic t_mode_decode;
    wr(2'd0, 16'h0000); rd(2'd0, 16'h0000, "R1 mode00 read");
    chk("R1 mode00", {i2s_master, i2s_slave}, 2'b00);
    wr(2'd0, 16'h0002); rd(2'd0, 16'h001A, "R1 mode01 read");
    chk("R1 mode01", {i2s_master, i2s_slave}, 2'b10);
    wr(2'd0, 16'h0004); rd(2'd0, 16'h001C, "R1 mode10 read");
    chk("R1 mode10", {i2s_master, i2s_slave}, 2'b01);
    wr(2'd0, 16'h0006); rd(2'd0, 16'h0006, "R1 mode11 read");
    chk("R1 mode11", {i2s_master, i2s_slave}, 2'b00);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_normal;
    wr(2'd0, 16'hA018); rd(2'd0, 16'hA018, "R2 word0");
    chk("R2 sync/net", {sync_mode, net_mode}, 2'b11);
    wr(2'd1, 16'h000C); rd(2'd1, 16'h000C, "R2 word1");
    chk("R2 tx bits", {tx_lsb_first, tx_clk_fall}, 2'b11);
    wr(2'd2, 16'h0001); rd(2'd2, 16'h0001, "R2 word2");
    chk("R2 rx bit", rx_lsb_first, 1);
    wr(2'd0, 16'h0000); wr(2'd1, 16'h0000); wr(2'd2, 16'h0000);
  endtask

  task automatic t_force_and_shadow;
    // opposite of the I2S values stored first
    wr(2'd1, 16'h0004); wr(2'd2, 16'h0001);
    wr(2'd0, 16'h0002);
    rd(2'd0, 16'h001A, "R3 word0 forced");
    chk("R3 sync/net", {sync_mode, net_mode}, 2'b11);
    rd(2'd1, 16'h0008, "R4 R5 word1 forced");
    rd(2'd2, 16'h0000, "R4 word2 forced");
    chk("R4 msb first", {tx_lsb_first, rx_lsb_first}, 2'b00);
    chk("R5 clk fall", tx_clk_fall, 1);
    // writes while master
    wr(2'd1, 16'h0003);
    rd(2'd1, 16'h000B, "R6 word1 non-forced updated");
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0004);
    chk("R6 slave entered", i2s_slave, 1);
    wr(2'd0, 16'h0018);  // normal + sync/net, judged against slave mode
    chk("R6 normal again", {i2s_master, i2s_slave}, 2'b00);
    rd(2'd0, 16'h0000, "R6 sync/net write dropped");
    rd(2'd1, 16'h0007, "R7 word1 shadow");
    rd(2'd2, 16'h0001, "R7 word2 shadow");
    chk("R7 outputs", {tx_lsb_first, tx_clk_fall, rx_lsb_first}, 3'b101);
    wr(2'd1, 16'h0000); wr(2'd2, 16'h0000);
  endtask

  task automatic t_flag;
    wr(2'd1, 16'h0003);
    tx_level = 5'd8;  rd(2'd0, 16'h0001, "R8 level==wm");
    chk("R10 irq all set", tx_empty_irq, 1);
    tx_level = 5'd9;  rd(2'd0, 16'h0000, "R8 level>wm");
    chk("R10 irq no flag", tx_empty_irq, 0);
    tx_level = 5'd0;  rd(2'd0, 16'h0001, "R8 level 0");
    wr(2'd3, 16'h0000);
    tx_level = 5'd0;  #1; chk("R8 wm0 lvl0", tx_empty, 1);
    tx_level = 5'd1;  #1; chk("R8 wm0 lvl1", tx_empty, 0);
    wr(2'd3, 16'h000F);
    tx_level = 5'd16; #1; chk("R8 wm15 lvl16", tx_empty, 0);
    tx_level = 5'd15; #1; chk("R8 wm15 lvl15", tx_empty, 1);
    wr(2'd1, 16'h0002);
    tx_level = 5'd0;  rd(2'd0, 16'h0000, "R9 fifo off flag");
    chk("R10 irq no fifo", tx_empty_irq, 0);
    wr(2'd1, 16'h0001);
    chk("R10 flag w/o ien", tx_empty, 1);
    chk("R10 irq no ien", tx_empty_irq, 0);
    wr(2'd1, 16'h0000); wr(2'd3, 16'h0008); tx_level = 5'd15;
  endtask

  task automatic t_readonly;
    tx_level = 5'd0;
    wr(2'd0, 16'h0001);
    rd(2'd0, 16'h0000, "R12 flag bit not writable");
    wr(2'd1, 16'h0001);
    rd(2'd0, 16'h0001, "R12 flag bit live");
    wr(2'd1, 16'h0000);
    wr(2'd3, 16'hFFF5);
    rd(2'd3, 16'h0005, "R12 word3 upper zero");
    tx_level = 5'd15;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_decode();
    t_normal();
    t_force_and_shadow();
    t_flag();
    t_readonly();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule